// File: doc/BRIEF.md
# Zero-Register Two-Read Register File

This block is the architectural integer register store of a single-cycle datapath. It holds 32 entries of 64 bits. Two operand selects choose two entries, and both values appear on the read data outputs within the same cycle, with no clock edge in between. One write channel stores a value into one entry at the rising clock edge when its enable is high.

Entry 0 has no flip-flops. It always reads as zero, and any write aimed at it is thrown away. This lets an instruction that names entry 0 as its destination act as a no-operation. A synchronous clear, which is active high, empties the whole store. Every entry also drives a debug bus, so surrounding logic and test equipment can watch the full architectural state.

The block is built from four parts: a write-select decoder, a storage bank whose entry 0 is a constant, and one read multiplexer for each read port. The top module places the multiplexer twice through a generate loop.

Top module: `zero_reg_file`

## Requirements
- R1: When `clr` is high at a rising edge, every entry reads zero after that edge, on `dbg_regs` and on both read ports.
- R2: When `wr_en` is 1 and `wr_sel` is not 0, the entry numbered `wr_sel` holds `wr_data` after the rising edge.
- R3: When `wr_en` is 0, no entry changes at the edge, whatever `wr_sel` and `wr_data` are.
- R4: Entry 0 always reads as zero. A write with `wr_sel` equal to 0 leaves every entry unchanged.
- R5: `rd_data_a` equals entry `rd_sel_a`, and it follows a change of `rd_sel_a` in the same cycle, with no clock edge.
- R6: `rd_data_b` equals entry `rd_sel_b`, independently of port A. Both ports may select the same entry or different entries.
- R7: When `clr` and `wr_en` are both high at one edge, the clear wins, and the addressed entry becomes zero.
- R8: A read of the entry being written returns the old value until the edge and the new value after it. There is no bypass.
- R9: A write changes only the addressed entry. All other entries keep their contents.
- R10: Slice `k` of `dbg_regs` (bits 64k+63 down to 64k) carries entry `k` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and the clear act on its rising edge |
| clr | input | 1 | Synchronous clear, active high; empties every entry |
| rd_sel_a | input | 5 | Entry number for read port A |
| rd_sel_b | input | 5 | Entry number for read port B |
| rd_data_a | output | 64 | Contents of the entry chosen by `rd_sel_a` (combinational) |
| rd_data_b | output | 64 | Contents of the entry chosen by `rd_sel_b` (combinational) |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Entry number to write |
| wr_data | input | 64 | Value to store |
| dbg_regs | output | 2048 | All 32 entries packed together; entry k sits at bits 64k+63 down to 64k |

## Verification
The hardest case to set up is a read of the entry that is being written in the same cycle. To observe it, the bench holds a read select equal to the write select, drives a fresh value with the enable high, and samples the read data twice: once before the edge, when it must still show the old value, and once after the edge, when it must show the new one. A second hard case is a clear and a write at the same edge. The bench sets up this collision deliberately and then confirms that the addressed entry is zero. The rest of the stimulus sweeps all 32 write targets and all 1024 pairs of read selects, and compares each result against a model of the store kept in the bench.

// File: rtl/zrf_pkg.sv
package zrf_pkg;

    localparam int unsigned DEF_ENTRIES = 32;
    localparam int unsigned DEF_WIDTH   = 64;

    // Width of a select that can address n entries (at least one bit)
    function automatic int unsigned sel_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/zrf_wr_decode.sv
module zrf_wr_decode #(
    parameter int unsigned ENTRIES = zrf_pkg::DEF_ENTRIES,
    parameter int unsigned SEL_W   = zrf_pkg::sel_bits(ENTRIES)
) (
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    output logic [ENTRIES-1:0] strobe
);

    // Entry 0 has no storage, so it never receives a write strobe
    assign strobe[0] = 1'b0;

    for (genvar g = 1; g < ENTRIES; g++) begin : g_dec
        assign strobe[g] = en && (sel == SEL_W'(g));
    end

    // R9: at most one entry is enabled for writing at any time
    always_comb begin
        a_r9_single_strobe: assert ($onehot0(strobe));
    end

endmodule

// File: rtl/zrf_bank.sv
module zrf_bank #(
    parameter int unsigned ENTRIES = zrf_pkg::DEF_ENTRIES,
    parameter int unsigned WIDTH   = zrf_pkg::DEF_WIDTH
) (
    input  logic                            clk,
    input  logic                            clr,
    input  logic [ENTRIES-1:0]              strobe,
    input  logic [WIDTH-1:0]                wdata,
    output logic [ENTRIES-1:0][WIDTH-1:0]   regs
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        if (g == 0) begin : g_zero
            // Constant zero; no flip-flops for this entry
            assign regs[g] = '0;
        end else begin : g_store
            logic [WIDTH-1:0] q;
            always_ff @(posedge clk) begin
                if (clr)
                    q <= '0;
                else if (strobe[g])
                    q <= wdata;
            end
            assign regs[g] = q;
        end
    end

    // R1: a clear leaves the whole bank empty
    a_r1_clear_empties: assert property (@(posedge clk)
        clr |=> (regs == '0));

    // R3: with no strobe the bank holds its contents
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (clr)
        (strobe == '0) |=> $stable(regs));

endmodule

// File: rtl/zrf_rd_port.sv
module zrf_rd_port #(
    parameter int unsigned ENTRIES = zrf_pkg::DEF_ENTRIES,
    parameter int unsigned WIDTH   = zrf_pkg::DEF_WIDTH,
    parameter int unsigned SEL_W   = zrf_pkg::sel_bits(ENTRIES)
) (
    input  logic [ENTRIES-1:0][WIDTH-1:0] regs,
    input  logic [SEL_W-1:0]              sel,
    output logic [WIDTH-1:0]              data
);

    assign data = regs[sel];

endmodule

// File: rtl/zero_reg_file.sv
module zero_reg_file #(
    parameter int unsigned ENTRIES = zrf_pkg::DEF_ENTRIES,
    parameter int unsigned WIDTH   = zrf_pkg::DEF_WIDTH,
    localparam int unsigned SEL_W  = zrf_pkg::sel_bits(ENTRIES),
    localparam int unsigned NPORTS = 2
) (
    input  logic                          clk,
    input  logic                          clr,
    input  logic [SEL_W-1:0]              rd_sel_a,
    input  logic [SEL_W-1:0]              rd_sel_b,
    output logic [WIDTH-1:0]              rd_data_a,
    output logic [WIDTH-1:0]              rd_data_b,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [WIDTH-1:0]              wr_data,
    output logic [ENTRIES-1:0][WIDTH-1:0] dbg_regs
);

    logic [ENTRIES-1:0]              strobe;
    logic [ENTRIES-1:0][WIDTH-1:0]   regs;
    logic [NPORTS-1:0][SEL_W-1:0]    port_sel;
    logic [NPORTS-1:0][WIDTH-1:0]    port_data;

    zrf_wr_decode #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_dec (
        .en     (wr_en),
        .sel    (wr_sel),
        .strobe (strobe)
    );

    zrf_bank #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_bank (
        .clk    (clk),
        .clr    (clr),
        .strobe (strobe),
        .wdata  (wr_data),
        .regs   (regs)
    );

    assign port_sel[0] = rd_sel_a;
    assign port_sel[1] = rd_sel_b;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        zrf_rd_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .SEL_W(SEL_W)) u_rd (
            .regs (regs),
            .sel  (port_sel[p]),
            .data (port_data[p])
        );
    end

    assign rd_data_a = port_data[0];
    assign rd_data_b = port_data[1];
    assign dbg_regs  = regs;

    // R2: an enabled write to a non-zero entry lands in that entry
    a_r2_write_lands: assert property (@(posedge clk) disable iff (clr)
        (wr_en && wr_sel != '0) |=> (dbg_regs[$past(wr_sel)] == $past(wr_data)));

    // R4: a write aimed at entry 0 changes nothing
    a_r4_zero_discard: assert property (@(posedge clk) disable iff (clr)
        (wr_en && wr_sel == '0) |=> (dbg_regs == $past(dbg_regs)));

    // R5: port A matches the debug view of its selected entry
    a_r5_port_a_match: assert property (@(posedge clk) disable iff (clr)
        rd_data_a == dbg_regs[rd_sel_a]);

    // R6: port B matches the debug view of its selected entry
    a_r6_port_b_match: assert property (@(posedge clk) disable iff (clr)
        rd_data_b == dbg_regs[rd_sel_b]);

endmodule

// File: tb/zero_reg_file_test.sv
`timescale 1ns/1ps
module zero_reg_file_test;

    localparam int N = 32;
    localparam int W = 64;

    logic             clk = 1'b0;
    logic             clr;
    logic [4:0]       rd_sel_a, rd_sel_b, wr_sel;
    logic [W-1:0]     rd_data_a, rd_data_b, wr_data;
    logic             wr_en;
    logic [N-1:0][W-1:0] dbg_regs;

    logic [W-1:0] model [N];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    zero_reg_file uut (
        .clk(clk), .clr(clr),
        .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .dbg_regs(dbg_regs)
    );

    function automatic logic [W-1:0] pat(input int i, input int salt);
        logic [31:0] hi, lo;
        hi = 32'hA500_0000 + 32'(i) * 32'h0101_0101 + 32'(salt);
        lo = ~(32'h5A5A_0000 + 32'(i) * 32'h0000_1003 + 32'(salt) * 32'h77);
        return {hi, lo};
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < N; k++) check(req, dbg_regs[k], model[k]);
    endtask

    // Drive at the falling edge, let the rising edge act, sample 1 ns after it
    task automatic step(input logic c, input logic en, input int sel, input logic [W-1:0] d);
        @(negedge clk);
        clr = c; wr_en = en; wr_sel = 5'(sel); wr_data = d;
        @(posedge clk); #1;
        if (c) begin
            for (int k = 0; k < N; k++) model[k] = '0;
        end else if (en && sel != 0) begin
            model[sel] = d;
        end
        @(negedge clk);
        clr = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        clr = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rd_sel_a = '0; rd_sel_b = '0;
        for (int k = 0; k < N; k++) model[k] = '0;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        check_all("R1 reset");
        for (int k = 0; k < N; k++) begin
            rd_sel_a = 5'(k); #0.1;
            check("R1 read after clear", rd_data_a, '0);
        end

        // R2, R9, R10: write each entry in turn, whole store compared each time
        for (int i = 0; i < N; i++) begin
            step(1'b0, 1'b1, i, pat(i, 1));
            check_all("R9 R10 write sweep");
            if (i != 0) check("R2 written value", dbg_regs[i], pat(i, 1));
        end
        // R4: entry 0 stayed zero after a write aimed at it
        check("R4 entry zero", dbg_regs[0], '0);
        step(1'b0, 1'b1, 0, {W{1'b1}});
        check_all("R4 write to zero discarded");

        // R5, R6: every pair of read selects, sampled without an edge
        @(negedge clk);
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                rd_sel_a = 5'(a); rd_sel_b = 5'(b); #0.05;
                check("R5 port A", rd_data_a, model[a]);
                check("R6 port B", rd_data_b, model[b]);
            end
        end

        // R3: disabled writes leave everything unchanged
        for (int i = 0; i < N; i += 3) begin
            step(1'b0, 1'b0, i, pat(i, 9));
            check_all("R3 disabled write");
        end

        // R8: same-cycle read of the entry being written
        @(negedge clk);
        rd_sel_a = 5'd7; rd_sel_b = 5'd7;
        wr_en = 1'b1; wr_sel = 5'd7; wr_data = pat(7, 42);
        #1;
        check("R8 old value before edge", rd_data_a, pat(7, 1));
        check("R8 port B old value before edge", rd_data_b, pat(7, 1));
        @(posedge clk); #1;
        model[7] = pat(7, 42);
        check("R8 new value after edge", rd_data_a, pat(7, 42));
        check("R8 port B new value after edge", rd_data_b, pat(7, 42));
        @(negedge clk); wr_en = 1'b0;

        // R7: clear and write at the same edge
        step(1'b1, 1'b1, 12, pat(12, 5));
        check("R7 clear beats write", dbg_regs[12], '0);
        check_all("R7 R1 store empty");
        rd_sel_a = 5'd12; #0.1;
        check("R7 read port", rd_data_a, '0);

        // Rewrite after clear with a second pattern, then read back on both ports
        for (int i = N - 1; i >= 0; i--) step(1'b0, 1'b1, i, pat(i, 3));
        check_all("R2 R9 second pattern");
        for (int k = 0; k < N; k++) begin
            rd_sel_a = 5'(k); rd_sel_b = 5'(N - 1 - k); #0.1;
            check("R5 reread", rd_data_a, model[k]);
            check("R6 reread", rd_data_b, model[N - 1 - k]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule